// File: doc/BRIEF.md
# Multiplexed LED Panel Refresh Controller

This block keeps a 19-row by 32-column multiplexed LED panel lit. The panel holds no image of its own: its column drivers are a chain of serial-in shift registers, and the picture survives only while the controller keeps streaming. The 32 columns are split into eight groups of four adjacent columns. Each refresh phase lights one column position in every group at once, so a full frame takes four phases. The controller runs through them forever, with no pause.

For each phase the controller first shifts out a column-select byte, then one 24-bit word per group. After the last bit it pulls the active-low output enable low for a programmable number of system clocks. That pulse width sets the brightness. A host fills a small on-chip frame store through a plain write port, one 19-bit row word per (phase, group) entry. The controller copies the eight words of a phase into a private buffer at the start of that phase, so host writes never tear a phase that is already being sent.

The serial clock is the system clock divided by `2*CLK_DIV`. For the 3 MHz limit at 100 MHz, `CLK_DIV` must be at least 17.

Top module: `led_mux_refresh`

## Requirements
- R1: Each phase begins with an 8-bit column-select byte sent MSB first. It holds the phase number (0, 1, 2 or 3) in its two low bits, and its upper six bits are zero.
- R2: The select byte is followed by exactly 8 group words of 24 bits each, 200 bits per phase in total. The words go from group 7 down to group 0. Each word is 5 zero padding bits followed by rows 18 down to 0, and row r takes bit r of the frame-store entry (current phase, group).
- R3: The serial clock idles low and each high half lasts exactly `CLK_DIV` system clocks. Data changes only on the cycle the serial clock falls, so serial data is stable for the whole high half.
- R4: Output enable stays high for all 200 shifts of a phase and goes low on the cycle the last bit's clock falls. It stays low for `oe_width` system clocks, sampled at that moment; a width of 0 gives 1 clock.
- R5: `phase_done` pulses high for exactly one cycle, on the cycle output enable returns high, once per phase.
- R6: Phases run 0, 1, 2, 3, 0, ... without stopping. The first serial clock rise of a phase comes exactly `CLK_DIV + 1` system clocks after that phase's predecessor raised `phase_done`.
- R7: A host write to entry (p, g) leaves the phase currently being sent unchanged and is shown from the next load of phase p onward.
- R8: While `rst_n` is low, output enable is high and `sclk`, `sdo` and `phase_done` are low. Reset clears the frame store, and the first phase sent after reset is phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Frame-store write strobe |
| wr_phase | input | 2 | Phase (column position) of the entry written |
| wr_group | input | 3 | Column group of the entry written |
| wr_data | input | 19 | Row bits for the entry, bit r = row r |
| oe_width | input | 16 | Output-enable low time in system clocks (0 acts as 1) |
| sdo | output | 1 | Serial data to the shift-register chain |
| sclk | output | 1 | Serial shift clock |
| oe_n | output | 1 | Active-low output enable of the panel registers |
| phase_done | output | 1 | One-cycle strobe at the end of each enable pulse |

## Verification
The bench goes after bit order with walking-one and hashed row patterns. A design that reversed the group order, reversed the rows or misplaced the padding would put lit pixels in the wrong column or row. It rewrites the whole store in the middle of a phase. A design without the per-phase copy would show part of the new image in that phase, and a design that copied at the wrong time would never show the new image. It sets the enable width to 0 and to small values. A design that counted the width wrongly would run dim or bright, and one that opened output enable before the final shift would flash a half-shifted pattern. Finally, it measures every serial clock high half and the gap between phases. A slow divider would exceed the shift-register clock limit, and a missing phase or an extra cycle in the gap would show up as flicker.

// File: rtl/ledp_pkg.sv
// Package: shared types for the LED panel refresh controller.
// Assumes: nothing beyond a standard SystemVerilog tool flow.
package ledp_pkg;

    // Top-level sequencing states of one refresh phase.
    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_OE    = 2'd2
    } ledp_state_e;

endpackage

// File: rtl/ledp_frame_store.sv
// Module: ledp_frame_store
// Holds one row word per (phase, group) entry, written by the host, and
// copies the words of one phase into a buffer when ld_en is high.
// Assumes: PHASES and GROUPS are powers of two, so the address is a concatenation.
module ledp_frame_store #(
    parameter int PHASES = 4,
    parameter int GROUPS = 8,
    parameter int ROWS   = 19,
    parameter int PH_W   = $clog2(PHASES),
    parameter int GR_W   = $clog2(GROUPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [PH_W-1:0]          wr_phase,
    input  logic [GR_W-1:0]          wr_group,
    input  logic [ROWS-1:0]          wr_data,
    input  logic                     ld_en,
    input  logic [PH_W-1:0]          ld_phase,
    output logic [GROUPS*ROWS-1:0]   phase_buf
);
    localparam int ENTRIES = PHASES * GROUPS;
    localparam int ADDR_W  = PH_W + GR_W;

    logic [ROWS-1:0]   mem [ENTRIES];
    logic [ADDR_W-1:0] wr_addr;

    assign wr_addr = {wr_phase, wr_group};

    // Host write port; reset clears every entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // One loader per group: snapshot of the selected phase.
    for (genvar g = 0; g < GROUPS; g++) begin : g_load
        logic [ADDR_W-1:0] rd_addr;
        assign rd_addr = {ld_phase, GR_W'(g)};

        // Capture this group's word at the phase boundary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                phase_buf[g*ROWS +: ROWS] <= '0;
            end else if (ld_en) begin
                phase_buf[g*ROWS +: ROWS] <= mem[rd_addr];
            end
        end
    end

endmodule

// File: rtl/ledp_sclk_div.sv
// Module: ledp_sclk_div
// Emits a one-cycle tick every CLK_DIV system clocks while run is high.
// The counter restarts from zero whenever run is low.
// Assumes: CLK_DIV >= 1.
module ledp_sclk_div #(
    parameter int CLK_DIV = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_DIV - 1);

    logic [DIV_W-1:0] cnt;

    // Half-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/ledp_bit_seq.sv
// Module: ledp_bit_seq
// Walks through the bit stream of one phase: the select byte, then one
// word per group from the highest group down, each word being zero padding
// followed by the rows from the highest down. Presents the current bit.
// Assumes: start and adv are never high together; GRP_BITS >= ROWS.
module ledp_bit_seq #(
    parameter int GROUPS   = 8,
    parameter int ROWS     = 19,
    parameter int SEL_BITS = 8,
    parameter int GRP_BITS = 24,
    parameter int PH_W     = 2,
    parameter int GR_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   adv,
    input  logic [PH_W-1:0]        phase,
    input  logic [GROUPS*ROWS-1:0] phase_buf,
    output logic                   bit_out,
    output logic                   last
);
    localparam int PAD    = GRP_BITS - ROWS;
    localparam int MAXW   = (GRP_BITS > SEL_BITS) ? GRP_BITS : SEL_BITS;
    localparam int SLOT_W = $clog2(MAXW);
    localparam int SEL_IW = (SEL_BITS > 1) ? $clog2(SEL_BITS) : 1;
    localparam int BUF_IW = $clog2(GROUPS * ROWS);

    logic              in_sel;
    logic [GR_W-1:0]   grp;
    logic [SLOT_W-1:0] slot;
    logic [SEL_BITS-1:0] sel_byte;
    logic [SEL_IW-1:0] sel_idx;
    logic [BUF_IW-1:0] row_idx;

    // Position counters: section, group and slot within the word.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            in_sel <= 1'b1;
            grp    <= GR_W'(GROUPS - 1);
            slot   <= '0;
        end else if (adv) begin
            if (in_sel) begin
                if (slot == SLOT_W'(SEL_BITS - 1)) begin
                    in_sel <= 1'b0;
                    slot   <= '0;
                end else begin
                    slot <= slot + 1'b1;
                end
            end else if (slot == SLOT_W'(GRP_BITS - 1)) begin
                slot <= '0;
                grp  <= grp - 1'b1;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

    assign sel_byte = SEL_BITS'(phase);
    assign sel_idx  = SEL_IW'(SEL_BITS - 1 - int'(slot));
    assign row_idx  = BUF_IW'(int'(grp) * ROWS + (ROWS - 1) - (int'(slot) - PAD));

    // Current bit value for the position held in the counters.
    always_comb begin
        if (in_sel) begin
            bit_out = sel_byte[sel_idx];
        end else if (int'(slot) < PAD) begin
            bit_out = 1'b0;
        end else begin
            bit_out = phase_buf[row_idx];
        end
    end

    assign last = !in_sel && (grp == '0) && (slot == SLOT_W'(GRP_BITS - 1));

endmodule

// File: rtl/led_mux_refresh.sv
// Module: led_mux_refresh (top)
// Refreshes a multiplexed LED panel without pause: per phase it loads the
// phase's row words, shifts out select byte and group words on sdo/sclk,
// then holds oe_n low for oe_width clocks and strobes phase_done.
// Assumes: COLS is a multiple of COLS_PER_GROUP; both quotients are powers of two.
module led_mux_refresh #(
    parameter int ROWS           = 19,
    parameter int COLS           = 32,
    parameter int COLS_PER_GROUP = 4,
    parameter int GRP_BITS       = 24,
    parameter int SEL_BITS       = 8,
    parameter int CLK_DIV        = 17,
    parameter int OE_W           = 16,
    localparam int GROUPS        = COLS / COLS_PER_GROUP,
    localparam int PHASES        = COLS_PER_GROUP,
    localparam int PH_W          = $clog2(PHASES),
    localparam int GR_W          = $clog2(GROUPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PH_W-1:0]   wr_phase,
    input  logic [GR_W-1:0]   wr_group,
    input  logic [ROWS-1:0]   wr_data,
    input  logic [OE_W-1:0]   oe_width,
    output logic              sdo,
    output logic              sclk,
    output logic              oe_n,
    output logic              phase_done
);
    import ledp_pkg::*;

    ledp_state_e            state;
    logic [PH_W-1:0]        phase;
    logic [OE_W-1:0]        oe_cnt;
    logic [GROUPS*ROWS-1:0] phase_buf;
    logic                   sclk_q, oe_q, done_q;
    logic                   tick, ld_en, run, adv, last, bit_out;

    assign ld_en = (state == ST_LOAD);
    assign run   = (state == ST_SHIFT);
    assign adv   = run && tick && sclk_q && !last;

    ledp_frame_store #(
        .PHASES (PHASES),
        .GROUPS (GROUPS),
        .ROWS   (ROWS),
        .PH_W   (PH_W),
        .GR_W   (GR_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_phase  (wr_phase),
        .wr_group  (wr_group),
        .wr_data   (wr_data),
        .ld_en     (ld_en),
        .ld_phase  (phase),
        .phase_buf (phase_buf)
    );

    ledp_sclk_div #(
        .CLK_DIV (CLK_DIV)
    ) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    ledp_bit_seq #(
        .GROUPS   (GROUPS),
        .ROWS     (ROWS),
        .SEL_BITS (SEL_BITS),
        .GRP_BITS (GRP_BITS),
        .PH_W     (PH_W),
        .GR_W     (GR_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ld_en),
        .adv       (adv),
        .phase     (phase),
        .phase_buf (phase_buf),
        .bit_out   (bit_out),
        .last      (last)
    );

    // Phase sequencer: load, shift, enable pulse, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_LOAD;
            phase  <= '0;
            sclk_q <= 1'b0;
            oe_q   <= 1'b1;
            done_q <= 1'b0;
            oe_cnt <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_LOAD: begin
                    state  <= ST_SHIFT;
                    sclk_q <= 1'b0;
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            if (last) begin
                                state  <= ST_OE;
                                oe_q   <= 1'b0;
                                oe_cnt <= (oe_width == '0) ? '0 : oe_width - 1'b1;
                            end
                        end
                    end
                end
                ST_OE: begin
                    if (oe_cnt == '0) begin
                        oe_q   <= 1'b1;
                        done_q <= 1'b1;
                        phase  <= (phase == PH_W'(PHASES - 1)) ? '0 : phase + 1'b1;
                        state  <= ST_LOAD;
                    end else begin
                        oe_cnt <= oe_cnt - 1'b1;
                    end
                end
                default: state <= ST_LOAD;
            endcase
        end
    end

    assign sdo        = run ? bit_out : 1'b0;
    assign sclk       = sclk_q;
    assign oe_n       = oe_q;
    assign phase_done = done_q;

endmodule

// File: rtl/ledp_refresh_chk.sv
// Module: ledp_refresh_chk
// Protocol checker for the panel serial stream, bound to led_mux_refresh.
// Assumes: it sees only the top-level ports.
module ledp_refresh_chk #(
    parameter int CLK_DIV = 17
) (
    input logic clk,
    input logic rst_n,
    input logic sdo,
    input logic sclk,
    input logic oe_n,
    input logic phase_done
);
    logic [15:0] hi_cnt;

    // Count the cycles the serial clock has been high.
    always_ff @(posedge clk) begin
        if (!rst_n || !sclk) hi_cnt <= '0;
        else                 hi_cnt <= hi_cnt + 1'b1;
    end

    // R3
    sclk_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_cnt == 16'(CLK_DIV)));

    // R3
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo));

    // R4
    oe_idle_while_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> oe_n);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_done |=> !phase_done);

    // R5
    done_at_oe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_done |-> (oe_n && !$past(oe_n)));

    // R8
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (oe_n && !sclk && !sdo && !phase_done));

endmodule

bind led_mux_refresh ledp_refresh_chk #(
    .CLK_DIV (CLK_DIV)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sdo        (sdo),
    .sclk       (sclk),
    .oe_n       (oe_n),
    .phase_done (phase_done)
);

// File: tb/led_mux_refresh_tb_top.sv
// Bench: captures whole phases at the ports and compares them with a
// stream built arithmetically from the written patterns.
module led_mux_refresh_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int ROWS       = 19;
    localparam int GROUPS     = 8;
    localparam int NBITS      = 8 + GROUPS * 24;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_phase = '0;
    logic [2:0]  wr_group = '0;
    logic [18:0] wr_data = '0;
    logic [15:0] oe_width = 16'd7;
    logic        sdo, sclk, oe_n, phase_done;

    int checks = 0;
    int fails  = 0;
    int since_done = 0;
    logic prev_sclk = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    led_mux_refresh #(.CLK_DIV(DIV)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_phase   (wr_phase),
        .wr_group   (wr_group),
        .wr_data    (wr_data),
        .oe_width   (oe_width),
        .sdo        (sdo),
        .sclk       (sclk),
        .oe_n       (oe_n),
        .phase_done (phase_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Pattern sets: 0 = cleared, 1 = hashed, 2 = walking one.
    function automatic logic [18:0] pat(input int which, input int p, input int g);
        case (which)
            1:       return 19'((p * 8 + g + 1) * 20071) ^ 19'(g << 9);
            2:       return 19'(1) << ((p * 5 + g) % 19);
            default: return '0;
        endcase
    endfunction

    function automatic logic exp_bit(input int which, input int p, input int k);
        int off, g, s;
        if (k < 8) return ((p >> (7 - k)) & 1) != 0;
        off = k - 8;
        g   = 7 - off / 24;
        s   = off % 24;
        if (s < 5) return 1'b0;
        return pat(which, p, g)[18 - (s - 5)];
    endfunction

    task automatic write_all(input int which);
        for (int p = 0; p < 4; p++) begin
            for (int g = 0; g < GROUPS; g++) begin
                @(negedge clk);
                wr_en    = 1'b1;
                wr_phase = 2'(p);
                wr_group = 3'(g);
                wr_data  = pat(which, p, g);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Capture one phase at the ports and check it.
    task automatic capture(input int ph, input int which, input int exp_oe, input bit chk_gap);
        logic [NBITS-1:0] bits = '0;
        int n = 0, hi = 0, hi_bad = 0, stab_bad = 0, early_oe = 0, oe_len = 0;
        int gap = -1, sel = 0, row_bad = 0, pad_bad = 0, first_bad = -1;
        logic last_sdo = 1'b0;
        bit done = 1'b0;
        while (!done) begin
            @(negedge clk);
            since_done++;
            if (sclk && !prev_sclk) begin
                if (n == 0) gap = since_done;
                if (n < NBITS) bits[n] = sdo;
                n++;
                hi = 1;
                last_sdo = sdo;
            end else if (sclk) begin
                hi++;
                if (sdo != last_sdo) stab_bad++;
            end else if (prev_sclk && hi != DIV) begin
                hi_bad++;
            end
            if (!oe_n) begin
                oe_len++;
                if (n < NBITS || sclk) early_oe++;
            end
            if (phase_done) begin
                done = 1'b1;
                since_done = 0;
                check(oe_n == 1'b1, "R5", "oe_n high at done", int'(oe_n), 1);
            end
            prev_sclk = sclk;
        end
        for (int k = 0; k < 8; k++) sel = (sel << 1) | int'(bits[k]);
        for (int k = 8; k < NBITS && k < n; k++) begin
            if (bits[k] != exp_bit(which, ph, k)) begin
                if (((k - 8) % 24) < 5) pad_bad++;
                else row_bad++;
                if (first_bad < 0) first_bad = k;
            end
        end
        check(sel == ph, "R1", "select byte", sel, ph);
        check(n == NBITS, "R2", "bits per phase", n, NBITS);
        check(pad_bad == 0, "R2", "padding bits wrong", pad_bad, 0);
        check(row_bad == 0, "R2/R7", "row bits wrong (first index in next line)", row_bad, 0);
        if (row_bad != 0) check(1'b0, "R2", "first bad bit index", first_bad, -1);
        check(hi_bad == 0, "R3", "sclk high width errors", hi_bad, 0);
        check(stab_bad == 0, "R3", "sdo changed while sclk high", stab_bad, 0);
        check(early_oe == 0, "R4", "oe_n low during shift", early_oe, 0);
        check(oe_len == exp_oe, "R4", "oe low width", oe_len, exp_oe);
        if (chk_gap) check(gap == DIV + 1, "R6", "phase gap", gap, DIV + 1);
        @(negedge clk);
        since_done++;
        check(phase_done == 1'b0, "R5", "done width", int'(phase_done), 0);
        prev_sclk = sclk;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state at the ports
        check(oe_n == 1'b1, "R8", "oe_n in reset", int'(oe_n), 1);
        check(sclk == 1'b0, "R8", "sclk in reset", int'(sclk), 0);
        check(sdo == 1'b0, "R8", "sdo in reset", int'(sdo), 0);
        check(phase_done == 1'b0, "R8", "phase_done in reset", int'(phase_done), 0);
        rst_n = 1'b1;
        prev_sclk = sclk;

        // R7/R8: cleared store shown on phase 0 even though writes land mid-phase
        fork
            capture(0, 0, 7, 1'b0);
            begin
                repeat (20) @(negedge clk);
                write_all(1);
            end
        join
        // R6/R7: new data appears at later phase loads, in order
        capture(1, 1, 7, 1'b1);
        capture(2, 1, 7, 1'b1);
        capture(3, 1, 7, 1'b1);
        capture(0, 1, 7, 1'b1);

        // R7: rewrite during phase 1; phase 1 keeps the old words
        fork
            capture(1, 1, 7, 1'b1);
            begin
                repeat (30) @(negedge clk);
                write_all(2);
            end
        join
        // R4: zero width acts as one clock
        oe_width = 16'd0;
        capture(2, 2, 1, 1'b1);
        oe_width = 16'd3;
        capture(3, 2, 3, 1'b1);
        oe_width = 16'd1;
        capture(0, 2, 1, 1'b1);
        oe_width = 16'd7;
        capture(1, 2, 7, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule